// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block chooses the three integer settings of a fractional-free PLL. They are the input pre-divider M, the feedback multiplier N and the output post-divider PL. The block takes a reference clock rate and a requested output rate, both in kHz. A single start pulse launches a sequential search over the legal settings. The search keeps the VCO and the phase-comparison frequency inside their limits, and it keeps the combination whose output lands nearest the request. When the search ends, the block reports the chosen settings, the output rate they actually give, and a one-cycle completion pulse.

All quotients come from one shared iterative restoring divider, so the engine holds no wide combinational dividers. Every candidate costs a small number of divides, in a fixed order. PL ascends on the outside, M ascends inside it, and N ascends innermost. This order decides which candidate wins a tie, and it decides where an early exit lands. A mode input selects between two searches. The exhaustive best-fit search stops only on an exact hit. The quick search also accepts the first improvement whose relative error is already small.

Top module: `pll_coef_search`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `no_match` are 0, and `m_out`, `n_out`, `pl_out` and `freq_out` are all 0.
- R2: `busy` rises in the cycle after an accepted `start` and stays high until the result is delivered. `done` is a single-cycle pulse, and during that cycle `busy` is already 0.
- R3: A `start` pulse that arrives while `busy` is high is ignored. The running search completes with the inputs captured at its own start.
- R4: PL is searched in ascending order, M ascending within each PL, and N ascending within each M. A candidate with zero error ends the search at once with that candidate.
- R5: When `best_fit`=1, the search is exhaustive unless an exact hit occurs. A stored candidate is replaced only by one with a strictly smaller error.
- R6: When `best_fit`=0, the search also ends at the first improving candidate whose VCO divided by its error (integer quotient) exceeds 218.
- R7: The target VCO is T + floor(T/50). PL runs from floor(VCO_min / target VCO) up to ceil(VCO_max / target VCO), with both bounds clamped into 1..31. For each PL the VCO goal is T x PL.
- R8: When the target VCO exceeds the upper VCO limit (2,600,000 kHz), that limit is raised to the target VCO, both for the PL bound and for the candidate VCO window.
- R9: For each M, the comparison rate is floor(ref/M). If it is below 12,000 the M loop for that PL ends. If it is above 38,400 that M is skipped. M runs from 1 to 255.
- R10: The N candidates for each M run from floor(goal x M / ref) to ceil(goal x M / ref). If the floor exceeds 255, the M loop ends. N below 8 is skipped, and N above 255 ends the N loop. A candidate counts only if its VCO, floor(ref x N / M), lies within 1,300,000 up to the (possibly raised) upper limit.
- R11: A candidate's output is floor((VCO + floor(PL/2)) / PL), and its error is the absolute difference from T. The reported `freq_out` is floor(ref x N / (M x PL)) for the chosen values.
- R12: If no candidate qualifies, `no_match` is 1 and the outputs carry the defaults M=255, N=8 and PL=1, with `freq_out` computed from them as in R11.
- R13: The outputs `m_out`, `n_out`, `pl_out`, `freq_out` and `no_match` change only in the cycle in which `done` is high. At all other times they hold their values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| ref_khz | input | FW (32) | Reference clock rate in kHz |
| tgt_khz | input | FW (32) | Requested output rate in kHz |
| best_fit | input | 1 | 1: exhaustive search, 0: allow early acceptance |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse, results valid |
| no_match | output | 1 | No candidate met the limits |
| m_out | output | 8 | Chosen pre-divider M |
| n_out | output | 8 | Chosen feedback multiplier N |
| pl_out | output | 5 | Chosen post-divider PL |
| freq_out | output | FW (32) | Output rate of the chosen settings in kHz |

## Verification
The assertions assume a nonzero reference and a nonzero target, so that no divisor in the search is ever zero. They also assume a target small enough that the rounded output stays within FW bits. The stimulus uses reference rates in the tens of MHz and targets between 128 MHz and 2.62 GHz, so every divide has a legal divisor. The search is launched only when the engine is idle, except in the one directed case that checks a start pulse is ignored while busy.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_TV,
      S_HI,
      S_LO,
      S_PL,
      S_U,
      S_NB,
      S_NC,
      S_VCO,
      S_OUT,
      S_RAT,
      S_FIN
   } pcs_state_e;

   // states whose work is a single division on the shared divider
   function automatic logic pcs_uses_div(pcs_state_e s);
      return s inside {S_TV, S_HI, S_LO, S_U, S_NB, S_VCO, S_OUT, S_RAT, S_FIN};
   endfunction

endpackage

// File: rtl/pcs_restoring_div.sv
module pcs_restoring_div #(
   parameter int DW  = 64,
   parameter int BPC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quo,
   output logic [DW-1:0] rem
);

   localparam int STEPS = DW / BPC;
   localparam int CW    = $clog2(STEPS + 1);

   generate
      if ((DW % BPC) != 0 || BPC < 1) begin : g_bad_bpc
         $error("pcs_restoring_div: DW must be a multiple of BPC");
      end
   endgenerate

   logic [DW-1:0] q_r, r_r, d_r;
   logic [CW-1:0] cnt;
   logic [DW-1:0] q_n, r_n;
   logic [DW:0]   trial;

   // BPC restoring steps chained per clock
   always_comb begin
      q_n   = q_r;
      r_n   = r_r;
      trial = '0;
      for (int i = 0; i < BPC; i++) begin
         trial = {r_n, q_n[DW-1]};
         q_n   = {q_n[DW-2:0], 1'b0};
         if (trial >= {1'b0, d_r}) begin
            r_n    = DW'(trial - {1'b0, d_r});
            q_n[0] = 1'b1;
         end else begin
            r_n = trial[DW-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r  <= '0;
         r_r  <= '0;
         d_r  <= '0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && cnt == '0) begin
            q_r <= dividend;
            r_r <= '0;
            d_r <= divisor;
            cnt <= CW'(STEPS);
         end else if (cnt != '0) begin
            q_r <= q_n;
            r_r <= r_n;
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) done <= 1'b1;
         end
      end
   end

   assign busy = (cnt != '0);
   assign quo  = q_r;
   assign rem  = r_r;

   // the controller never launches a divide over a running one
   p_go_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy);

   // a finished quotient leaves a remainder below the divisor (feeds R11 rounding)
   p_rem_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem < d_r));

endmodule

// File: rtl/pcs_best_track.sv
module pcs_best_track #(
   parameter int MW    = 8,
   parameter int NW    = 8,
   parameter int LW    = 5,
   parameter int EW    = 64,
   parameter int M_DEF = 255,
   parameter int N_DEF = 8,
   parameter int L_DEF = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd,
   input  logic [MW-1:0] cand_m,
   input  logic [NW-1:0] cand_n,
   input  logic [LW-1:0] cand_pl,
   input  logic [EW-1:0] cand_err,
   output logic          better,
   output logic          valid,
   output logic [MW-1:0] best_m,
   output logic [NW-1:0] best_n,
   output logic [LW-1:0] best_pl,
   output logic [EW-1:0] best_err
);

   // strictly smaller error wins; the first qualifying candidate always wins
   assign better = !valid || (cand_err < best_err);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         valid    <= 1'b0;
         best_m   <= MW'(M_DEF);
         best_n   <= NW'(N_DEF);
         best_pl  <= LW'(L_DEF);
         best_err <= '1;
      end else if (upd) begin
         valid    <= 1'b1;
         best_m   <= cand_m;
         best_n   <= cand_n;
         best_pl  <= cand_pl;
         best_err <= cand_err;
      end
   end

   // within one search the kept error never grows
   p_err_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(valid) && !$past(clr)) |-> (best_err <= $past(best_err)));

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
   import pcs_pkg::*;
#(
   parameter int unsigned FW      = 32,
   parameter int unsigned VCO_MIN = 1300000,
   parameter int unsigned VCO_MAX = 2600000,
   parameter int unsigned CMP_MIN = 12000,
   parameter int unsigned CMP_MAX = 38400,
   parameter int unsigned M_MIN   = 1,
   parameter int unsigned M_MAX   = 255,
   parameter int unsigned N_MIN   = 8,
   parameter int unsigned N_MAX   = 255,
   parameter int unsigned PL_MIN  = 1,
   parameter int unsigned PL_MAX  = 31,
   parameter int unsigned TV_DIV  = 50,
   parameter int unsigned RATIO   = 218,
   parameter int unsigned DIV_BPC = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [FW-1:0]                ref_khz,
   input  logic [FW-1:0]                tgt_khz,
   input  logic                         best_fit,
   output logic                         busy,
   output logic                         done,
   output logic                         no_match,
   output logic [$clog2(M_MAX+1)-1:0]   m_out,
   output logic [$clog2(N_MAX+1)-1:0]   n_out,
   output logic [$clog2(PL_MAX+1)-1:0]  pl_out,
   output logic [FW-1:0]                freq_out
);

   localparam int MW  = $clog2(M_MAX + 1);
   localparam int NW  = $clog2(N_MAX + 1);
   localparam int LW  = $clog2(PL_MAX + 1);
   localparam int NCW = NW + 1;
   localparam int PW  = 2 * FW;

   localparam logic [PW-1:0] K_VMIN  = PW'(VCO_MIN);
   localparam logic [PW-1:0] K_VMAX  = PW'(VCO_MAX);
   localparam logic [PW-1:0] K_UMIN  = PW'(CMP_MIN);
   localparam logic [PW-1:0] K_UMAX  = PW'(CMP_MAX);
   localparam logic [PW-1:0] K_NMIN  = PW'(N_MIN);
   localparam logic [PW-1:0] K_NMAX  = PW'(N_MAX);
   localparam logic [PW-1:0] K_PLMIN = PW'(PL_MIN);
   localparam logic [PW-1:0] K_PLMAX = PW'(PL_MAX);
   localparam logic [PW-1:0] K_RATIO = PW'(RATIO);
   localparam logic [PW-1:0] K_TVDIV = PW'(TV_DIV);

   generate
      if (VCO_MIN >= VCO_MAX || CMP_MIN > CMP_MAX || CMP_MIN == 0) begin : g_bad_rates
         $error("pll_coef_search: inconsistent rate limits");
      end
      if (M_MIN < 1 || M_MIN > M_MAX || N_MIN > N_MAX || PL_MIN < 1 || PL_MIN > PL_MAX) begin : g_bad_coef
         $error("pll_coef_search: inconsistent coefficient limits");
      end
      if (FW < 24 || TV_DIV == 0) begin : g_bad_width
         $error("pll_coef_search: FW too narrow or TV_DIV zero");
      end
   endgenerate

   pcs_state_e      st;
   logic            pend;
   logic [FW-1:0]   ref_r, tgt_r;
   logic            bf_r;
   logic [PW-1:0]   tv_r, maxv_r, goal_r, vco_r, dlt_r;
   logic [LW-1:0]   pl_hi, pl_c;
   logic [MW-1:0]   m_c;
   logic [NCW-1:0]  n_c, n_hi;

   logic            div_go, div_busy, div_done;
   logic [PW-1:0]   div_a, div_b, div_q, div_r, div_ceil, tv_n, cand_dlt;

   logic            trk_clr, trk_upd, trk_better, trk_valid;
   logic [MW-1:0]   best_m;
   logic [NW-1:0]   best_n;
   logic [LW-1:0]   best_pl;
   logic [PW-1:0]   best_dlt;

   logic            last_m, last_pl, adv_m, adv_pl, move_m, move_pl;

   function automatic logic [LW-1:0] clamp_pl(logic [PW-1:0] x);
      if (x > K_PLMAX)      return LW'(PL_MAX);
      else if (x < K_PLMIN) return LW'(PL_MIN);
      else                  return x[LW-1:0];
   endfunction

   assign busy     = (st != S_IDLE);
   assign div_ceil = div_q + PW'(div_r != '0);
   assign tv_n     = PW'(tgt_r) + div_q;
   assign cand_dlt = (div_q > PW'(tgt_r)) ? (div_q - PW'(tgt_r)) : (PW'(tgt_r) - div_q);
   assign last_m   = (m_c == MW'(M_MAX));
   assign last_pl  = (pl_c == pl_hi);
   assign div_go   = pcs_uses_div(st) && !pend && !div_busy;
   assign trk_clr  = (st == S_IDLE) && start;
   assign trk_upd  = (st == S_OUT) && div_done && trk_better;

   // operands of the single shared divider, one pair per state
   always_comb begin
      div_a = '0;
      div_b = PW'(1);
      case (st)
         S_TV:    begin div_a = PW'(tgt_r);               div_b = K_TVDIV;                   end
         S_HI:    begin div_a = maxv_r;                   div_b = tv_r;                      end
         S_LO:    begin div_a = K_VMIN;                   div_b = tv_r;                      end
         S_U:     begin div_a = PW'(ref_r);               div_b = PW'(m_c);                  end
         S_NB:    begin div_a = goal_r * PW'(m_c);        div_b = PW'(ref_r);                end
         S_VCO:   begin div_a = PW'(ref_r) * PW'(n_c);    div_b = PW'(m_c);                  end
         S_OUT:   begin div_a = vco_r + PW'(pl_c >> 1);   div_b = PW'(pl_c);                 end
         S_RAT:   begin div_a = vco_r;                    div_b = dlt_r;                     end
         S_FIN:   begin div_a = PW'(ref_r) * PW'(best_n); div_b = PW'(best_m) * PW'(best_pl); end
         default: ;
      endcase
   end

   // loop advance decisions: end of an M loop or skip to the next M
   always_comb begin
      adv_m  = 1'b0;
      adv_pl = 1'b0;
      case (st)
         S_U: if (div_done) begin
            if (div_q < K_UMIN)      adv_pl = 1'b1;
            else if (div_q > K_UMAX) adv_m  = 1'b1;
         end
         S_NB: if (div_done && div_q > K_NMAX) adv_pl = 1'b1;
         S_NC: if (n_c > n_hi || PW'(n_c) > K_NMAX) adv_m = 1'b1;
         default: ;
      endcase
      move_m  = adv_m && !last_m;
      move_pl = adv_pl || (adv_m && last_m);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         pend     <= 1'b0;
         ref_r    <= '0;
         tgt_r    <= '0;
         bf_r     <= 1'b0;
         tv_r     <= '0;
         maxv_r   <= '0;
         goal_r   <= '0;
         vco_r    <= '0;
         dlt_r    <= '0;
         pl_hi    <= '0;
         pl_c     <= '0;
         m_c      <= '0;
         n_c      <= '0;
         n_hi     <= '0;
         done     <= 1'b0;
         no_match <= 1'b0;
         m_out    <= '0;
         n_out    <= '0;
         pl_out   <= '0;
         freq_out <= '0;
      end else begin
         done <= 1'b0;
         if (div_go)        pend <= 1'b1;
         else if (div_done) pend <= 1'b0;

         if (move_pl) begin
            if (last_pl) st <= S_FIN;
            else begin
               pl_c <= pl_c + 1'b1;
               st   <= S_PL;
            end
         end else if (move_m) begin
            m_c <= m_c + 1'b1;
            st  <= S_U;
         end else begin
            case (st)
               S_IDLE: if (start) begin
                  ref_r <= ref_khz;
                  tgt_r <= tgt_khz;
                  bf_r  <= best_fit;
                  st    <= S_TV;
               end
               S_TV: if (div_done) begin
                  tv_r   <= tv_n;
                  maxv_r <= (tv_n > K_VMAX) ? tv_n : K_VMAX;
                  st     <= S_HI;
               end
               S_HI: if (div_done) begin
                  pl_hi <= clamp_pl(div_ceil);
                  st    <= S_LO;
               end
               S_LO: if (div_done) begin
                  pl_c <= clamp_pl(div_q);
                  st   <= S_PL;
               end
               S_PL: begin
                  goal_r <= PW'(tgt_r) * PW'(pl_c);
                  m_c    <= MW'(M_MIN);
                  st     <= S_U;
               end
               S_U: if (div_done) st <= S_NB;
               S_NB: if (div_done) begin
                  n_c  <= div_q[NCW-1:0];
                  n_hi <= div_ceil[NCW-1:0];
                  st   <= S_NC;
               end
               S_NC: begin
                  if (PW'(n_c) < K_NMIN) n_c <= n_c + 1'b1;
                  else                   st  <= S_VCO;
               end
               S_VCO: if (div_done) begin
                  vco_r <= div_q;
                  if (div_q >= K_VMIN && div_q <= maxv_r) st <= S_OUT;
                  else begin
                     n_c <= n_c + 1'b1;
                     st  <= S_NC;
                  end
               end
               S_OUT: if (div_done) begin
                  if (trk_better && cand_dlt == '0) st <= S_FIN;
                  else if (trk_better && !bf_r) begin
                     dlt_r <= cand_dlt;
                     st    <= S_RAT;
                  end else begin
                     n_c <= n_c + 1'b1;
                     st  <= S_NC;
                  end
               end
               S_RAT: if (div_done) begin
                  if (div_q > K_RATIO) st <= S_FIN;
                  else begin
                     n_c <= n_c + 1'b1;
                     st  <= S_NC;
                  end
               end
               S_FIN: if (div_done) begin
                  m_out    <= best_m;
                  n_out    <= best_n;
                  pl_out   <= best_pl;
                  freq_out <= div_q[FW-1:0];
                  no_match <= !trk_valid;
                  done     <= 1'b1;
                  st       <= S_IDLE;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   pcs_restoring_div #(.DW(PW), .BPC(int'(DIV_BPC))) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (div_a),
      .divisor  (div_b),
      .busy     (div_busy),
      .done     (div_done),
      .quo      (div_q),
      .rem      (div_r)
   );

   pcs_best_track #(
      .MW(MW), .NW(NW), .LW(LW), .EW(PW),
      .M_DEF(int'(M_MAX)), .N_DEF(int'(N_MIN)), .L_DEF(int'(PL_MIN))
   ) u_best (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (trk_clr),
      .upd      (trk_upd),
      .cand_m   (m_c),
      .cand_n   (n_c[NW-1:0]),
      .cand_pl  (pl_c),
      .cand_err (cand_dlt),
      .better   (trk_better),
      .valid    (trk_valid),
      .best_m   (best_m),
      .best_n   (best_n),
      .best_pl  (best_pl),
      .best_err (best_dlt)
   );

   p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_done_closes_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_hold_results_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(m_out) && $stable(n_out) && $stable(pl_out)
                 && $stable(freq_out) && $stable(no_match)));

   p_coef_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !no_match) |-> (m_out >= MW'(M_MIN) && n_out >= NW'(N_MIN)
                               && pl_out >= LW'(PL_MIN) && pl_out <= LW'(PL_MAX)));

   p_defaults_on_miss_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && no_match) |-> (m_out == MW'(M_MAX) && n_out == NW'(N_MIN)
                              && pl_out == LW'(PL_MIN)));

   p_pl_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_U) |-> (pl_c <= pl_hi && pl_c >= LW'(PL_MIN)));

endmodule

// File: tb/sim_pll_coef_search.sv
module sim_pll_coef_search;

   localparam int CLK_NS = 10;
   localparam int WAIT_LIMIT = 30000;
   localparam int NV = 7;

   // stimulus and hand-derived expectations
   localparam int unsigned V_REF [NV] = '{38400, 38400, 38400, 12000, 50000, 38400, 10000};
   localparam int unsigned V_TGT [NV] = '{1300000, 1300000, 1920000, 128000, 2000000, 2620000, 1300000};
   localparam int unsigned V_BF  [NV] = '{1, 0, 1, 1, 1, 1, 1};
   localparam int unsigned V_M   [NV] = '{3, 1, 1, 1, 2, 3, 255};
   localparam int unsigned V_N   [NV] = '{203, 34, 50, 128, 80, 205, 8};
   localparam int unsigned V_PL  [NV] = '{2, 1, 1, 12, 1, 1, 1};
   localparam int unsigned V_F   [NV] = '{1299200, 1305600, 1920000, 128000, 2000000, 2624000, 313};
   localparam int unsigned V_E   [NV] = '{0, 0, 0, 0, 0, 0, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ref_i = '0;
   logic [31:0] tgt_i = '0;
   logic        bf_i = 1'b0;
   logic        busy, done, no_match;
   logic [7:0]  m_o, n_o;
   logic [4:0]  pl_o;
   logic [31:0] f_o;

   int nchk = 0;
   int nbad = 0;

   always #(CLK_NS/2) clk = ~clk;

   pll_coef_search u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ref_khz  (ref_i),
      .tgt_khz  (tgt_i),
      .best_fit (bf_i),
      .busy     (busy),
      .done     (done),
      .no_match (no_match),
      .m_out    (m_o),
      .n_out    (n_o),
      .pl_out   (pl_o),
      .freq_out (f_o)
   );

   function automatic string vtag(int i);
      case (i)
         0: return "R5";
         1: return "R6";
         2: return "R4";
         3: return "R7";
         4: return "R9";
         5: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_done();
      int w = 0;
      while (!done && w < WAIT_LIMIT) begin
         @(negedge clk);
         w++;
      end
      if (!done) chk("R2 done never seen", 0, 1);
   endtask

   // R2: busy after start, busy low with done, done one cycle long
   task automatic launch(input int unsigned r, input int unsigned t, input int unsigned b);
      @(negedge clk);
      ref_i = r;
      tgt_i = t;
      bf_i  = b[0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy after start", busy, 1);
   endtask

   task automatic finish_run();
      wait_done();
      chk("R2 busy low at done", busy, 0);
      @(negedge clk);
      chk("R2 done single cycle", done, 0);
   endtask

   task automatic expect_res(input int i, input string tg);
      chk(tg, m_o, V_M[i]);
      chk("R10", n_o, V_N[i]);
      chk(tg, pl_o, V_PL[i]);
      chk("R11", f_o, V_F[i]);
      chk("R12", no_match, V_E[i]);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state under reset
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 m", m_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 n", n_o, 0);
      chk("R1 pl", pl_o, 0);
      chk("R1 freq", f_o, 0);
      chk("R1 no_match", no_match, 0);

      for (int i = 0; i < NV; i++) begin
         launch(V_REF[i], V_TGT[i], V_BF[i]);
         finish_run();
         expect_res(i, vtag(i));
      end

      // R3: a second start during a run must not take effect
      launch(V_REF[2], V_TGT[2], V_BF[2]);
      repeat (3) @(negedge clk);
      ref_i = V_REF[6];
      tgt_i = V_TGT[6];
      bf_i  = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish_run();
      chk("R3 m", m_o, V_M[2]);
      chk("R3 n", n_o, V_N[2]);
      chk("R3 freq", f_o, V_F[2]);
      chk("R3 no_match", no_match, 0);
      repeat (4) @(negedge clk);
      chk("R3 no late run", busy, 0);

      // R13: results hold while idle and inputs move
      ref_i = 32'd19200;
      tgt_i = 32'd777777;
      bf_i  = 1'b0;
      repeat (40) @(negedge clk);
      chk("R13 m held", m_o, V_M[2]);
      chk("R13 pl held", pl_o, V_PL[2]);
      chk("R13 freq held", f_o, V_F[2]);
      chk("R13 idle", busy, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

endmodule